// File: doc/BRIEF.md
# Interrupt Service Tracker with End-of-Interrupt Handling

This block keeps the interrupt state of one processor core across 256 vectors. Incoming requests land in a pending set, and each one records whether it is edge- or level-triggered. The block picks the highest pending vector that may interrupt the core. A vector may interrupt only if its priority class is above the class held in a task-priority register and above the class of the highest vector already in service. The block offers that vector to the core, and the core accepts it with an acknowledge pulse. On acknowledge the vector leaves the pending set and enters the in-service set.

Software ends a handler by writing to the end-of-interrupt register through a simple register write port. That write retires the highest in-service vector, which may let a lower pending class through. If the retired vector was level-triggered, the block emits a one-cycle broadcast pulse that names it. In extended register mode only a zero-valued end-of-interrupt write counts. Any other value raises a one-cycle fault and leaves all state as it was. Requests of the special kinds (non-maskable, management, init, external, start-up and their kin) are flagged by the requester and are never tracked.

Top module: `irq_svc_tracker`

## Requirements
- R1: After reset the in-service and trigger-mode sets and the task-priority class are zero. `int_valid`, `eoi_bcast_valid` and `eoi_fault` are low.
- R2: A request with `req_special`=0 marks its vector pending from the next cycle. `int_vector` shows the highest-numbered pending vector, and while nothing changes the offer holds steady.
- R3: A write to offset 0x080 loads the task-priority class from `wr_data[7:4]`. A vector is offered only when its class `vector[7:4]` is strictly greater than that class.
- R4: A vector is offered only when its class is strictly greater than the class of the highest in-service vector. An empty in-service set counts as class 0, so vectors 0x00–0x0F are never offered.
- R5: When `int_ack` is high while `int_valid` is high, the offered vector leaves the pending set and enters the in-service set on that clock edge.
- R6: An accepted write to offset 0x0B0 (end of interrupt) clears only the highest-numbered in-service vector.
- R7: If the vector retired by an end-of-interrupt write was requested with `req_level`=1, then in the next cycle `eoi_bcast_valid` is high for exactly one cycle and `eoi_bcast_vec` holds that vector. For an edge-triggered vector (`req_level`=0) no pulse is emitted.
- R8: An end-of-interrupt write while the in-service set is empty changes nothing and produces no broadcast pulse.
- R9: With `ext_mode`=1, an end-of-interrupt write with nonzero data raises `eoi_fault` for one cycle, one cycle later, and changes no state. A zero-valued write is accepted. With `ext_mode`=0 any data value is accepted.
- R10: A request with `req_special`=1 sets no pending, in-service or trigger-mode bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Interrupt request strobe |
| req_vector | input | 8 | Requested vector number |
| req_level | input | 1 | 1 = level-triggered, 0 = edge-triggered |
| req_special | input | 1 | 1 = special delivery kind, not tracked |
| int_valid | output | 1 | A vector is offered to the core |
| int_vector | output | 8 | Offered vector |
| int_ack | input | 1 | Core accepts the offered vector |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 12 | Register write offset |
| wr_data | input | 32 | Register write data |
| ext_mode | input | 1 | Extended register mode: only zero-valued end-of-interrupt writes are accepted |
| eoi_bcast_valid | output | 1 | One-cycle end-of-interrupt broadcast pulse |
| eoi_bcast_vec | output | 8 | Vector named by the broadcast |
| eoi_fault | output | 1 | One-cycle pulse for a rejected end-of-interrupt write |

## Verification
Three requests of different classes arrive together. This shows that the offer follows vector order and not arrival order, and that the in-service class holds lower classes back until an end-of-interrupt write. A higher class arrives while a lower one is in service, and then two end-of-interrupt writes follow. A request that only the higher retirement can release tells apart clearing the highest in-service bit from clearing any other bit. The broadcast queue tells a level-triggered retirement from an edge-triggered one. Task-priority writes just at and just below a pending class expose an off-by-one in the gate. In extended mode, a nonzero write against a vector that would otherwise be released shows that a rejected write changes nothing. An empty-set write and a special request should leave the outputs quiet.

// File: rtl/irq_svc_pkg.sv
package irq_svc_pkg;

   // classification of one register-port write
   typedef enum logic [1:0] {
      WR_IDLE    = 2'd0,
      WR_PRIO    = 2'd1,
      WR_EOI_OK  = 2'd2,
      WR_EOI_BAD = 2'd3
   } wr_kind_e;

endpackage

// File: rtl/irq_top_find.sv
module irq_top_find #(
   parameter int N         = 256,
   parameter bit TWO_LEVEL = 1'b1,
   parameter int GROUP     = 16,
   localparam int IW       = $clog2(N)
) (
   input  logic [N-1:0]  vec,
   output logic          found,
   output logic [IW-1:0] idx
);

   if (N != (1 << IW)) begin : g_chk_pow2
      $error("irq_top_find: N must be a power of two");
   end

   if (TWO_LEVEL) begin : g_two_level
      localparam int NG  = N / GROUP;
      localparam int GW  = $clog2(GROUP);
      localparam int GIW = $clog2(NG);

      if ((GROUP < 2) || (NG < 2) || ((NG * GROUP) != N) || (GROUP != (1 << GW))) begin : g_chk_grp
         $error("irq_top_find: GROUP must be a power of two that splits N into two or more groups");
      end

      logic [NG-1:0]         grp_any;
      logic [NG-1:0][GW-1:0] grp_idx;
      logic [GIW-1:0]        sel;

      for (genvar g = 0; g < NG; g++) begin : g_grp
         logic [GW-1:0] loc;
         always_comb begin
            loc = '0;
            for (int b = 0; b < GROUP; b++) begin
               if (vec[g*GROUP + b]) loc = GW'(b);
            end
         end
         assign grp_idx[g] = loc;
         assign grp_any[g] = |vec[g*GROUP +: GROUP];
      end

      always_comb begin
         sel = '0;
         for (int g = 0; g < NG; g++) begin
            if (grp_any[g]) sel = GIW'(g);
         end
      end

      assign found = |grp_any;
      assign idx   = {sel, grp_idx[sel]};
   end else begin : g_linear
      always_comb begin
         found = 1'b0;
         idx   = '0;
         for (int i = 0; i < N; i++) begin
            if (vec[i]) begin
               found = 1'b1;
               idx   = IW'(i);
            end
         end
      end
   end

endmodule

// File: rtl/irq_wr_decode.sv
module irq_wr_decode
   import irq_svc_pkg::*;
#(
   parameter int              ADDR_W  = 12,
   parameter int              DATA_W  = 32,
   parameter logic [ADDR_W-1:0] EOI_OFF = 12'h0B0,
   parameter logic [ADDR_W-1:0] TPR_OFF = 12'h080
) (
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              ext_mode,
   output wr_kind_e          kind
);

   if (EOI_OFF == TPR_OFF) begin : g_chk_off
      $error("irq_wr_decode: the two register offsets must differ");
   end

   logic data_zero;
   assign data_zero = (wr_data == '0);

   always_comb begin
      kind = WR_IDLE;
      if (wr_en) begin
         if (wr_addr == TPR_OFF) begin
            kind = WR_PRIO;
         end else if (wr_addr == EOI_OFF) begin
            kind = (ext_mode && !data_zero) ? WR_EOI_BAD : WR_EOI_OK;
         end
      end
   end

endmodule

// File: rtl/irq_vec_state.sv
module irq_vec_state #(
   parameter int N     = 256,
   localparam int VW   = $clog2(N)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          set_go,
   input  logic [VW-1:0] set_vec,
   input  logic          set_level,
   input  logic          ack_go,
   input  logic [VW-1:0] ack_vec,
   input  logic          ret_go,
   input  logic [VW-1:0] ret_vec,
   output logic [N-1:0]  pend,
   output logic [N-1:0]  insvc,
   output logic [N-1:0]  trig
);

   logic [N-1:0] set_hot, ack_hot, ret_hot;

   for (genvar v = 0; v < N; v++) begin : g_hot
      assign set_hot[v] = set_go && (set_vec == VW'(v));
      assign ack_hot[v] = ack_go && (ack_vec == VW'(v));
      assign ret_hot[v] = ret_go && (ret_vec == VW'(v));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend  <= '0;
         insvc <= '0;
         trig  <= '0;
      end else begin
         pend  <= (pend & ~ack_hot) | set_hot;
         insvc <= (insvc | ack_hot) & ~ret_hot;
         trig  <= (trig & ~set_hot) | (set_hot & {N{set_level}});
      end
   end

endmodule

// File: rtl/irq_svc_tracker.sv
module irq_svc_tracker
   import irq_svc_pkg::*;
#(
   parameter int              NUM_VEC   = 256,
   parameter int              CLS_W     = 4,
   parameter int              ADDR_W    = 12,
   parameter int              DATA_W    = 32,
   parameter logic [ADDR_W-1:0] EOI_OFF = 12'h0B0,
   parameter logic [ADDR_W-1:0] TPR_OFF = 12'h080,
   parameter bit              TWO_LEVEL = 1'b1,
   parameter int              GROUP     = 16,
   localparam int             VEC_W     = $clog2(NUM_VEC)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [VEC_W-1:0]  req_vector,
   input  logic              req_level,
   input  logic              req_special,
   output logic              int_valid,
   output logic [VEC_W-1:0]  int_vector,
   input  logic              int_ack,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              ext_mode,
   output logic              eoi_bcast_valid,
   output logic [VEC_W-1:0]  eoi_bcast_vec,
   output logic              eoi_fault
);

   if ((VEC_W <= CLS_W) || (DATA_W < VEC_W)) begin : g_chk_widths
      $error("irq_svc_tracker: class field must be narrower than the vector and fit the data word");
   end

   wr_kind_e             kind;
   logic [NUM_VEC-1:0]   pend, insvc, trig;
   logic                 pend_found, isr_found;
   logic [VEC_W-1:0]     pend_top, isr_top;
   logic [CLS_W-1:0]     tpr_cls;
   logic [CLS_W-1:0]     pend_cls, isr_cls;
   logic                 ack_go, ret_go;

   irq_wr_decode #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W),
      .EOI_OFF(EOI_OFF),
      .TPR_OFF(TPR_OFF)
   ) u_dec (
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .ext_mode(ext_mode),
      .kind    (kind)
   );

   irq_top_find #(.N(NUM_VEC), .TWO_LEVEL(TWO_LEVEL), .GROUP(GROUP)) u_find_pend (
      .vec  (pend),
      .found(pend_found),
      .idx  (pend_top)
   );

   irq_top_find #(.N(NUM_VEC), .TWO_LEVEL(TWO_LEVEL), .GROUP(GROUP)) u_find_isr (
      .vec  (insvc),
      .found(isr_found),
      .idx  (isr_top)
   );

   assign pend_cls   = pend_top[VEC_W-1 -: CLS_W];
   assign isr_cls    = isr_found ? isr_top[VEC_W-1 -: CLS_W] : '0;
   assign int_valid  = pend_found && (pend_cls > tpr_cls) && (pend_cls > isr_cls);
   assign int_vector = pend_top;
   assign ack_go     = int_ack && int_valid;
   assign ret_go     = (kind == WR_EOI_OK) && isr_found;

   irq_vec_state #(.N(NUM_VEC)) u_state (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_go   (req_valid && !req_special),
      .set_vec  (req_vector),
      .set_level(req_level),
      .ack_go   (ack_go),
      .ack_vec  (pend_top),
      .ret_go   (ret_go),
      .ret_vec  (isr_top),
      .pend     (pend),
      .insvc    (insvc),
      .trig     (trig)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tpr_cls         <= '0;
         eoi_bcast_valid <= 1'b0;
         eoi_bcast_vec   <= '0;
         eoi_fault       <= 1'b0;
      end else begin
         if (kind == WR_PRIO) tpr_cls <= wr_data[VEC_W-1 -: CLS_W];
         eoi_bcast_valid <= ret_go && trig[isr_top];
         if (ret_go) eoi_bcast_vec <= isr_top;
         eoi_fault       <= (kind == WR_EOI_BAD);
      end
   end

endmodule

// File: rtl/irq_svc_tracker_chk.sv
module irq_svc_tracker_chk #(
   parameter int              CLS_W   = 4,
   parameter int              ADDR_W  = 12,
   parameter int              DATA_W  = 32,
   parameter int              VEC_W   = 8,
   parameter logic [ADDR_W-1:0] EOI_OFF = 12'h0B0,
   parameter logic [ADDR_W-1:0] TPR_OFF = 12'h080
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_special,
   input logic              int_valid,
   input logic [VEC_W-1:0]  int_vector,
   input logic              int_ack,
   input logic              wr_en,
   input logic [ADDR_W-1:0] wr_addr,
   input logic [DATA_W-1:0] wr_data,
   input logic              ext_mode,
   input logic              eoi_bcast_valid,
   input logic              eoi_fault
);

   logic [CLS_W-1:0] shadow_cls;
   logic             eoi_wr, eoi_bad, eoi_ok;

   assign eoi_wr  = wr_en && (wr_addr == EOI_OFF);
   assign eoi_bad = eoi_wr && ext_mode && (wr_data != '0);
   assign eoi_ok  = eoi_wr && !eoi_bad;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) shadow_cls <= '0;
      else if (wr_en && (wr_addr == TPR_OFF)) shadow_cls <= wr_data[VEC_W-1 -: CLS_W];
   end

   // R3: offered class is above the programmed task class
   assert_tpr_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
      int_valid |-> (int_vector[VEC_W-1 -: CLS_W] > shadow_cls));

   // R2: an untouched offer stays put
   assert_offer_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (int_valid && !int_ack && !wr_en && !req_valid) |=> (int_valid && $stable(int_vector)));

   // R9: rejected write faults and broadcasts nothing
   assert_fault_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      eoi_bad |=> (eoi_fault && !eoi_bcast_valid));

   // R9: fault only follows a rejected write
   assert_fault_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
      eoi_fault |-> $past(eoi_bad));

   // R7: broadcast only follows an accepted end-of-interrupt write
   assert_bcast_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
      eoi_bcast_valid |-> $past(eoi_ok));

   // R10: a special request cannot create an offer
   assert_special_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_special && !int_valid && !wr_en && !int_ack) |=> !int_valid);

endmodule

bind irq_svc_tracker irq_svc_tracker_chk #(
   .CLS_W  (CLS_W),
   .ADDR_W (ADDR_W),
   .DATA_W (DATA_W),
   .VEC_W  (VEC_W),
   .EOI_OFF(EOI_OFF),
   .TPR_OFF(TPR_OFF)
) u_chk (.*);

// File: tb/irq_svc_tracker_tb.sv
`timescale 1ns/1ps
module irq_svc_tracker_tb;

   localparam logic [11:0] EOI_A = 12'h0B0;
   localparam logic [11:0] TPR_A = 12'h080;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [7:0]  req_vector = '0;
   logic        req_level = 1'b0;
   logic        req_special = 1'b0;
   logic        int_valid;
   logic [7:0]  int_vector;
   logic        int_ack = 1'b0;
   logic        wr_en = 1'b0;
   logic [11:0] wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic        ext_mode = 1'b0;
   logic        eoi_bcast_valid;
   logic [7:0]  eoi_bcast_vec;
   logic        eoi_fault;

   int n_chk = 0;
   int n_bad = 0;
   logic [7:0] exp_q[$];
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   irq_svc_tracker u_dut (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_vector(req_vector), .req_level(req_level), .req_special(req_special),
      .int_valid(int_valid), .int_vector(int_vector), .int_ack(int_ack),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .ext_mode(ext_mode),
      .eoi_bcast_valid(eoi_bcast_valid), .eoi_bcast_vec(eoi_bcast_vec), .eoi_fault(eoi_fault)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic send_req(input logic [7:0] v, input logic lvl, input logic spc);
      req_valid = 1'b1; req_vector = v; req_level = lvl; req_special = spc;
      @(negedge clk);
      req_valid = 1'b0; req_special = 1'b0;
   endtask

   task automatic take(input string req, input logic [7:0] v);
      chk({req, " offer valid"}, 32'(int_valid), 32'd1);
      chk({req, " offer vector"}, 32'(int_vector), 32'(v));
      int_ack = 1'b1;
      @(negedge clk);
      int_ack = 1'b0;
   endtask

   // driver: pushes the expected broadcast before the write reaches the design
   task automatic reg_wr(input string req, input logic [11:0] a, input logic [31:0] d,
                         input logic exp_fault, input logic exp_bc, input logic [7:0] bvec);
      if (exp_bc) exp_q.push_back(bvec);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
      chk({req, " fault"}, 32'(eoi_fault), 32'(exp_fault));
   endtask

   task automatic idle_chk(input string req, input logic exp_valid, input logic [7:0] v);
      chk({req, " valid"}, 32'(int_valid), 32'(exp_valid));
      if (exp_valid) chk({req, " vector"}, 32'(int_vector), 32'(v));
   endtask

   // monitor: every broadcast pulse must match the head of the queue
   initial begin
      forever begin
         @(negedge clk);
         if (rst_n && eoi_bcast_valid) begin
            n_chk++;
            if (exp_q.size() == 0) begin
               n_bad++;
               $display("FAIL R7/R8 unexpected broadcast actual=%0h expected=none", eoi_bcast_vec);
            end else begin
               logic [7:0] e;
               e = exp_q.pop_front();
               if (eoi_bcast_vec !== e) begin
                  n_bad++;
                  $display("FAIL R7 broadcast vector actual=%0h expected=%0h", eoi_bcast_vec, e);
               end
            end
         end
      end
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset values
      chk("R1 valid in reset", 32'(int_valid), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 valid", 32'(int_valid), 32'd0);
      chk("R1 broadcast", 32'(eoi_bcast_valid), 32'd0);
      chk("R1 fault", 32'(eoi_fault), 32'd0);

      // R2 highest vector wins regardless of arrival order
      send_req(8'h45, 1'b0, 1'b0);
      send_req(8'h62, 1'b1, 1'b0);
      send_req(8'h30, 1'b0, 1'b0);
      idle_chk("R2 highest pending", 1'b1, 8'h62);
      @(negedge clk);
      idle_chk("R2 offer steady", 1'b1, 8'h62);
      take("R5 ack 62", 8'h62);
      // R4 lower classes held behind class 6 in service
      idle_chk("R4 blocked by in-service", 1'b0, 8'h00);
      // R9 legacy mode accepts nonzero data; R7 level vector broadcasts
      reg_wr("R9 legacy nonzero eoi", EOI_A, 32'h1234, 1'b0, 1'b1, 8'h62);
      idle_chk("R6 next after eoi", 1'b1, 8'h45);
      take("R5 ack 45", 8'h45);
      idle_chk("R4 30 behind 45", 1'b0, 8'h00);
      reg_wr("R7 edge eoi no pulse", EOI_A, 32'h0, 1'b0, 1'b0, 8'h00);
      idle_chk("R2 30 offered", 1'b1, 8'h30);
      // R3 task class equal blocks, lower lets through
      reg_wr("R3 tpr write 30", TPR_A, 32'h30, 1'b0, 1'b0, 8'h00);
      idle_chk("R3 equal class blocked", 1'b0, 8'h00);
      reg_wr("R3 tpr write 2f", TPR_A, 32'h2F, 1'b0, 1'b0, 8'h00);
      idle_chk("R3 lower class passes", 1'b1, 8'h30);
      take("R5 ack 30", 8'h30);

      // R9 extended mode
      send_req(8'h35, 1'b0, 1'b0);
      idle_chk("R4 same class blocked", 1'b0, 8'h00);
      ext_mode = 1'b1;
      reg_wr("R9 nonzero eoi faults", EOI_A, 32'h5, 1'b1, 1'b0, 8'h00);
      idle_chk("R9 no state change", 1'b0, 8'h00);
      @(negedge clk);
      chk("R9 fault one cycle", 32'(eoi_fault), 32'd0);
      reg_wr("R9 zero eoi accepted", EOI_A, 32'h0, 1'b0, 1'b0, 8'h00);
      idle_chk("R9 released 35", 1'b1, 8'h35);
      take("R5 ack 35", 8'h35);
      reg_wr("R9 zero eoi retires 35", EOI_A, 32'h0, 1'b0, 1'b0, 8'h00);
      // R8 empty in-service set
      reg_wr("R8 eoi on empty set", EOI_A, 32'h0, 1'b0, 1'b0, 8'h00);
      idle_chk("R8 still idle", 1'b0, 8'h00);
      chk("R8 no broadcast", 32'(eoi_bcast_valid), 32'd0);

      // R10 special request is not tracked
      send_req(8'h90, 1'b1, 1'b1);
      idle_chk("R10 special ignored", 1'b0, 8'h00);
      @(negedge clk);
      idle_chk("R10 special still ignored", 1'b0, 8'h00);

      // R6 nested service, retire highest first
      send_req(8'h50, 1'b1, 1'b0);
      take("R5 ack 50", 8'h50);
      send_req(8'hA0, 1'b0, 1'b0);
      idle_chk("R4 preempt", 1'b1, 8'hA0);
      take("R5 ack A0", 8'hA0);
      send_req(8'h70, 1'b0, 1'b0);
      idle_chk("R4 70 blocked by A0", 1'b0, 8'h00);
      reg_wr("R6 eoi retires A0", EOI_A, 32'h0, 1'b0, 1'b0, 8'h00);
      idle_chk("R6 70 released", 1'b1, 8'h70);
      take("R5 ack 70", 8'h70);
      reg_wr("R6 eoi retires 70", EOI_A, 32'h0, 1'b0, 1'b0, 8'h00);
      reg_wr("R7 eoi retires level 50", EOI_A, 32'h0, 1'b0, 1'b1, 8'h50);

      // R4 class 0 never offered with empty set
      ext_mode = 1'b0;
      reg_wr("R3 tpr clear", TPR_A, 32'h0, 1'b0, 1'b0, 8'h00);
      send_req(8'h0F, 1'b0, 1'b0);
      idle_chk("R4 class zero held", 1'b0, 8'h00);

      repeat (3) @(negedge clk);
      chk("R7 all broadcasts seen", 32'(exp_q.size()), 32'd0);
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
   end

endmodule